// File: doc/BRIEF.md
# Loop-Free Graph Depth Evaluator

This block analyses a small directed graph held as an adjacency matrix. It decides whether the graph contains any loop. When the graph is loop-free, it reports how many arcs the longest path has and the order that follows from that length, which is the longest path plus one. Such graphs come up when the memory span, definiteness or decoding delay of a state machine or a code is examined. The matrix is written one row per cycle. A start pulse begins the analysis, and a one-cycle done pulse marks the moment the result outputs become valid.

The analysis works by peeling. Every cycle of evaluation removes, all at once, each live vertex that has no arc to another live vertex (a sink). The number of such passes equals the number of vertices on the longest path. If a pass finds no sink while live vertices remain, the remaining vertices must contain a loop. A vertex-valid mask, captured at start, selects which of the parameterised NV vertices take part.

The controller has three states. ST_IDLE accepts row writes and start. ST_PEEL removes sinks once per cycle. ST_REPORT lasts one cycle and raises done. Its transitions are:
- IDLE to PEEL when start is seen.
- PEEL to PEEL while sinks exist.
- PEEL to REPORT when no live vertex remains (loop-free result) or when no sink exists among the live vertices (loop result).
- REPORT to IDLE unconditionally.

Top module: `dag_depth_checker`

## Requirements
- R1: After reset, done, loop_found, order and longest_path are 0, and row_ready is 1.
- R2: When row_valid and row_ready are both 1 at a clock edge, bit j of row_bits becomes the arc from vertex row_idx to vertex j (1 = arc present). The stored rows stay until they are written again.
- R3: row_ready is 0 from the edge that accepts start until the cycle after done. A row offered during that time is not stored.
- R4: For a loop-free graph whose longest path has l arcs, order is l+1 and longest_path is l. With no arcs among the live vertices, order is 1.
- R5: If the live vertices contain a loop, loop_found is 1 and order and longest_path are 0. A 1 on the diagonal (an arc from a vertex to itself) counts as a loop.
- R6: Only vertices whose bit in vtx_valid is 1 at the start edge take part, and arcs touching any other vertex are disregarded. Changes to vtx_valid after start have no effect on the run.
- R7: An empty vertex set gives order 0, longest_path 0 and loop_found 0.
- R8: done is high for exactly one cycle. It rises P+1 clock edges after the start edge, where P is the number of passes that removed vertices. For a loop-free graph, P equals order.
- R9: order, longest_path and loop_found keep their values until the run begun by the next accepted start ends.
- R10: A start that arrives while an evaluation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | Row write request |
| row_ready | output | 1 | High when a row write is accepted (idle) |
| row_idx | input | IW | Source vertex of the row being written |
| row_bits | input | NV | Arc bits from row_idx, bit j = arc to vertex j |
| vtx_valid | input | NV | Vertices taking part, captured at start |
| start | input | 1 | Begin evaluation (accepted in idle only) |
| done | output | 1 | One-cycle result-valid pulse |
| loop_found | output | 1 | Live subgraph contains a loop |
| longest_path | output | CW | Arcs on the longest path (loop-free only) |
| order | output | CW | Longest path plus one; 0 for loop or empty graph |

## Verification
Some properties are checked by assertions on every cycle:
- done never lasts two cycles.
- A loop result always carries zero order and zero path length.
- Results stay stable while idle.
- The live set only shrinks, and shrinks strictly, from one pass to the next.
- A row write lands in the addressed row.

Other behaviours can only be shown by the bench's scenarios, each compared with a behavioural height-relaxation model:
- Whether the reported order is correct for chains, branching graphs, self-loops, multi-vertex cycles, masked-out cycles and the empty set.
- The exact cycle of done.
- Whether a start or row write offered mid-run truly leaves the run and the stored matrix untouched.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEEL   = 2'd1,
        ST_REPORT = 2'd2
    } peel_state_t;
endpackage

// File: rtl/adj_store.sv
module adj_store #(
    parameter int NV = 8,
    localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [NV-1:0]          wr_row,
    output logic [NV-1:0][NV-1:0]  rows
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows <= '0;
        end else if (wr_en && (int'(wr_idx) < NV)) begin
            rows[wr_idx] <= wr_row;
        end
    end

    // R2: an accepted write is found in the addressed row one cycle later
    p_row_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NV)) |=> (rows[$past(wr_idx)] == $past(wr_row)));
endmodule

// File: rtl/sink_finder.sv
module sink_finder #(
    parameter int NV = 8
) (
    input  logic [NV-1:0][NV-1:0] rows,
    input  logic [NV-1:0]         live,
    output logic [NV-1:0]         sinks
);
    for (genvar gi = 0; gi < NV; gi++) begin : g_vtx
        assign sinks[gi] = live[gi] & ~(|(rows[gi] & live));
    end
endmodule

// File: rtl/dag_depth_checker.sv
module dag_depth_checker #(
    parameter int NV = 8,
    localparam int IW = (NV > 1) ? $clog2(NV) : 1,
    localparam int CW = $clog2(NV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_valid,
    output logic          row_ready,
    input  logic [IW-1:0] row_idx,
    input  logic [NV-1:0] row_bits,
    input  logic [NV-1:0] vtx_valid,
    input  logic          start,
    output logic          done,
    output logic          loop_found,
    output logic [CW-1:0] longest_path,
    output logic [CW-1:0] order
);
    import dag_pkg::*;

    peel_state_t state, state_nx;
    logic [NV-1:0]         live;
    logic [NV-1:0]         sinks;
    logic [CW-1:0]         pass_cnt;
    logic [NV-1:0][NV-1:0] rows;
    logic                  live_empty;
    logic                  stuck;
    logic                  finish;

    assign row_ready  = (state == ST_IDLE);
    assign done       = (state == ST_REPORT);
    assign live_empty = (live == '0);
    assign stuck      = !live_empty && (sinks == '0);
    assign finish     = live_empty || stuck;

    adj_store #(.NV(NV)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (row_valid && row_ready),
        .wr_idx (row_idx),
        .wr_row (row_bits),
        .rows   (rows)
    );

    sink_finder #(.NV(NV)) u_sinks (
        .rows  (rows),
        .live  (live),
        .sinks (sinks)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)  state_nx = ST_PEEL;
            ST_PEEL:   if (finish) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register with live set and pass counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            live     <= '0;
            pass_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                live     <= vtx_valid;
                pass_cnt <= '0;
            end else if (state == ST_PEEL && !finish) begin
                live     <= live & ~sinks;
                pass_cnt <= pass_cnt + 1'b1;
            end
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_found   <= 1'b0;
            order        <= '0;
            longest_path <= '0;
        end else if (state == ST_PEEL) begin
            if (live_empty) begin
                loop_found   <= 1'b0;
                order        <= pass_cnt;
                longest_path <= (pass_cnt == '0) ? '0 : pass_cnt - 1'b1;
            end else if (stuck) begin
                loop_found   <= 1'b1;
                order        <= '0;
                longest_path <= '0;
            end
        end
    end

    // R8: done never holds for two cycles
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a loop result carries no order
    p_loop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_found |-> (order == '0 && longest_path == '0));

    // R9: results stay put while idle without start
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=>
            ($stable(order) && $stable(loop_found) && $stable(longest_path)));

    // R4: every continuing pass strictly shrinks the live set
    p_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEEL && !finish) |=>
            (((live & ~$past(live)) == '0) && (live != $past(live))));

    // R3: no row is accepted while busy
    p_busy_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEEL) |-> !row_ready);
endmodule

// File: tb/dag_depth_checker_bench.sv
module dag_depth_checker_bench;
    localparam int NV = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_valid = 1'b0;
    logic          row_ready;
    logic [IW-1:0] row_idx = '0;
    logic [NV-1:0] row_bits = '0;
    logic [NV-1:0] vtx_valid = '0;
    logic          start = 1'b0;
    logic          done;
    logic          loop_found;
    logic [CW-1:0] longest_path;
    logic [CW-1:0] order;

    int n_vec = 0;
    int n_bad = 0;
    logic [NV-1:0] mir [NV];
    logic [NV-1:0] g   [NV];

    always #5 clk = ~clk;

    dag_depth_checker #(.NV(NV)) u_dag_depth_checker (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_ready(row_ready),
        .row_idx(row_idx), .row_bits(row_bits), .vtx_valid(vtx_valid),
        .start(start), .done(done), .loop_found(loop_found),
        .longest_path(longest_path), .order(order)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural height relaxation: height = vertices on longest path from v
    task automatic ref_eval(input logic [NV-1:0] mask, output int ord,
                            output bit lp, output int passes);
        int h [NV];
        int nh [NV];
        for (int v = 0; v < NV; v++) h[v] = 0;
        for (int it = 0; it < NV + 2; it++) begin
            for (int v = 0; v < NV; v++) begin
                int best = 0;
                if (mask[v]) begin
                    for (int u = 0; u < NV; u++)
                        if (mask[u] && mir[v][u] && h[u] > best) best = h[u];
                    nh[v] = (best + 1 > NV + 1) ? NV + 1 : best + 1;
                end else nh[v] = 0;
            end
            for (int v = 0; v < NV; v++) h[v] = nh[v];
        end
        lp = 1'b0; passes = 0;
        for (int v = 0; v < NV; v++) begin
            if (h[v] > NV) lp = 1'b1;
            else if (h[v] > passes) passes = h[v];
        end
        ord = lp ? 0 : passes;
    endtask

    task automatic load_graph();
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk(row_ready == 1'b1, "R2 ready", int'(row_ready), 1);
            row_valid = 1'b1; row_idx = IW'(i); row_bits = g[i];
            mir[i] = g[i];
            @(negedge clk);
            row_valid = 1'b0;
        end
    endtask

    task automatic run_eval(input logic [NV-1:0] mask, input bit poke, input string tag);
        int ord; bit lp; int passes;
        ref_eval(mask, ord, lp, passes);
        if (poke && passes < 2) poke = 1'b0;
        @(negedge clk);
        vtx_valid = mask; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= passes + 1; k++) begin
            @(posedge clk); #1;
            chk(done == (k == passes + 1), {tag, " R8 done timing"}, int'(done), int'(k == passes + 1));
            if (k <= passes)
                chk(row_ready == 1'b0, {tag, " R3 busy"}, int'(row_ready), 0);
            if (poke && k == 1) begin
                @(negedge clk);
                start = 1'b1; row_valid = 1'b1; row_idx = IW'(NV - 1);
                row_bits = NV'(1) << (NV - 1); vtx_valid = '0;
            end
            if (poke && k == 2) begin
                @(negedge clk);
                start = 1'b0; row_valid = 1'b0; vtx_valid = mask;
            end
        end
        chk(loop_found == lp, {tag, " R5 loop_found"}, int'(loop_found), int'(lp));
        chk(int'(order) == ord, {tag, " R4 order"}, int'(order), ord);
        chk(int'(longest_path) == ((ord == 0) ? 0 : ord - 1), {tag, " R4 longest_path"},
            int'(longest_path), (ord == 0) ? 0 : ord - 1);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk(done == 1'b0, {tag, " R8 single pulse"}, int'(done), 0);
            chk(int'(order) == ord && loop_found == lp, {tag, " R9 hold"}, int'(order), ord);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NV; i++) mir[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(done == 0 && loop_found == 0, "R1 flags", int'(done) + int'(loop_found), 0);
        chk(order == 0 && longest_path == 0, "R1 result", int'(order), 0);
        chk(row_ready == 1, "R1 ready", int'(row_ready), 1);

        // chain 0->1->...->7, with mid-run start, row write and mask change (R10, R3, R6)
        for (int i = 0; i < NV; i++) g[i] = (i < NV - 1) ? (NV'(1) << (i + 1)) : '0;
        load_graph();
        run_eval('1, 1'b1, "chain-poke R10");
        run_eval('1, 1'b0, "chain-rerun R3 R10");

        // self-loop on diagonal
        g[3] = g[3] | (NV'(1) << 3);
        load_graph();
        run_eval('1, 1'b0, "selfloop R5");

        // three-vertex cycle plus feeder, others isolated
        for (int i = 0; i < NV; i++) g[i] = '0;
        g[0] = 8'h02; g[1] = 8'h04; g[2] = 8'h01; g[3] = 8'h01;
        load_graph();
        run_eval('1, 1'b0, "cycle R5");
        // cycle masked out: only 0->1 remains (R6)
        run_eval(8'h03, 1'b0, "masked R6");
        run_eval(8'h08, 1'b0, "feeder-only R6");

        // empty set
        run_eval('0, 1'b0, "empty R7");

        // no arcs
        for (int i = 0; i < NV; i++) g[i] = '0;
        load_graph();
        run_eval('1, 1'b0, "no-arcs R4");

        // branching DAG: i->j for j>i where (i+j)%3==0
        for (int i = 0; i < NV; i++) begin
            g[i] = '0;
            for (int j = i + 1; j < NV; j++) if ((i + j) % 3 == 0) g[i][j] = 1'b1;
        end
        load_graph();
        run_eval('1, 1'b0, "branch R4");
        run_eval(8'b1011_0110, 1'b0, "branch-mask R6");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule